// File: doc/BRIEF.md
# Serial Byte Buffer Register Block with Interrupt Mask

This block is the register-level front end of a single-wire serial bus controller. Behind one data register it keeps a one-byte transmit slot and a one-byte receive slot. It holds an eight-flag status word and an eight-bit interrupt mask, and it drives one interrupt line. Software reaches it through a plain 32-bit port made of an address, a write strobe, a read strobe and write data. Read data is returned combinationally in the same cycle as the read strobe.

The bus side is modelled with handshakes. The transmit side sees the pending byte and a "slot full" indication, and pulses `tx_take` when it consumes the byte. The receive side pulses `rx_strobe` together with a new byte. Four other bus events arrive as single-cycle pulses: sync seen, conflict, transmitter off and bus inactive.

Accesses to the data register have side effects. A write fills the transmit slot, or, if the slot is occupied, is refused and flagged as a collision. A read returns the receive slot and marks it consumed. Event flags are sticky until software clears them by writing ones to the status register.

Top module: `sbuf_ctrl`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0x04 (only TX-empty, bit 2, set), the mask register reads 0, `tx_full` is 0 and `irq` is 0.
- R2: A write to offset 0x08 while the transmit slot is empty stores bits 7:0 in the slot (visible on `tx_byte`), sets `tx_full` and clears TX-empty (status bit 2) from the next cycle.
- R3: A write to offset 0x08 while the transmit slot is full leaves the slot byte unchanged and sets the write-collision flag (status bit 5).
- R4: A `tx_take` pulse while the slot is full empties it: `tx_full` drops and TX-empty (bit 2) is set from the next cycle.
- R5: An `rx_strobe` sets RX-full (status bit 1). A read of offset 0x08 returns the receive byte in bits 7:0 with bits 31:8 zero, and clears RX-full from the next cycle.
- R6: An `rx_strobe` while RX-full is already set, with no data read in the same cycle, sets RX-overflow (status bit 4), and the new byte replaces the old one.
- R7: Pulses on `ev_sync`, `ev_conflict`, `ev_txoff` and `ev_inactive` set status bits 0, 3, 6 and 7, and these bits stay set until cleared.
- R8: Writing to offset 0x04 clears each event flag (bits 0, 3, 4, 5, 6, 7) whose write-data bit is 1. Bits 1 and 2 of that write have no effect.
- R9: The mask register at offset 0x0C stores write-data bits 7:0 and reads back with bits 31:8 zero. All reads have bits 31:8 at zero.
- R10: `irq` is the OR over all eight bits of (status AND mask), registered, so it follows a change of status or mask one clock later.
- R11: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte offset inside the register window |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 32 | Read data, valid while reg_rd and reg_addr are held |
| tx_byte | output | 8 | Byte waiting in the transmit slot |
| tx_full | output | 1 | Transmit slot holds a byte |
| tx_take | input | 1 | Transmitter consumes the slot byte |
| rx_byte | input | 8 | Received byte |
| rx_strobe | input | 1 | Received byte is valid this cycle |
| ev_sync | input | 1 | Sync detected pulse |
| ev_conflict | input | 1 | Bus conflict pulse |
| ev_txoff | input | 1 | Transmitter switched off pulse |
| ev_inactive | input | 1 | Bus inactivity pulse |
| irq | output | 1 | Interrupt request |

## Verification
A wrong slot state appears at the ports at once. A lost or duplicated transmit byte changes `tx_byte` and `tx_full` on the clock edge after the access. A wrong receive state shows up on the next data or status read. A sticky flag that decays, or a clear that reaches the wrong bit, shows up on the following status read. A wrong mask or a wrong combining term shows on `irq` exactly one cycle after the status or mask changes, so the bench samples `irq` both before and after that edge to catch a missing or an extra register stage.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   localparam int NUM_FLAGS = 8;
   // flag positions: software decodes status and mask by these bits
   localparam int FLG_SYNC = 0;
   localparam int FLG_RXF  = 1;
   localparam int FLG_TXE  = 2;
   localparam int FLG_CONF = 3;
   localparam int FLG_OVF  = 4;
   localparam int FLG_COLL = 5;
   localparam int FLG_TOFF = 6;
   localparam int FLG_IDLE = 7;
   typedef logic [NUM_FLAGS-1:0] flags_t;
endpackage

// File: rtl/sbuf_tx_slot.sv
module sbuf_tx_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              take,
   output logic [DATA_W-1:0] hold_byte,
   output logic              full,
   output logic              coll
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_byte <= '0;
         full      <= 1'b0;
      end else if (wr_en && !full) begin
         hold_byte <= wr_byte;
         full      <= 1'b1;
      end else if (take && full) begin
         full      <= 1'b0;
      end
   end

   assign coll = wr_en && full;

   AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full) |=> (full && hold_byte == $past(wr_byte))); // R2
   AST_COLL_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> (hold_byte == $past(hold_byte))); // R3
   AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && full) |=> !full); // R4
endmodule

// File: rtl/sbuf_rx_slot.sv
module sbuf_rx_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              rd_en,
   output logic [DATA_W-1:0] hold_byte,
   output logic              full,
   output logic              ovf
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_byte <= '0;
         full      <= 1'b0;
      end else if (strobe) begin
         hold_byte <= byte_in;
         full      <= 1'b1;
      end else if (rd_en) begin
         full      <= 1'b0;
      end
   end

   // a refill counts as overflow only if the old byte was not read this cycle
   assign ovf = strobe && full && !rd_en;

   AST_RX_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> (full && hold_byte == $past(byte_in))); // R6
   AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !strobe) |=> !full); // R5
endmodule

// File: rtl/sbuf_irq_gen.sv
module sbuf_irq_gen
   import sbuf_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  flags_t flags,
   input  flags_t mask,
   output logic   irq
);
   logic hit;
   assign hit = |(flags & mask);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = hit;
   end
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
   import sbuf_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int BUS_W    = 32,
   parameter int DATA_W   = 8,
   parameter int OFS_STAT = 4,
   parameter int OFS_DATA = 8,
   parameter int OFS_MASK = 12,
   parameter bit IRQ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_full,
   input  logic              tx_take,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_strobe,
   input  logic              ev_sync,
   input  logic              ev_conflict,
   input  logic              ev_txoff,
   input  logic              ev_inactive,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

   if (DATA_W < NUM_FLAGS || DATA_W >= BUS_W) begin : g_bad_width
      $error("sbuf_ctrl: need NUM_FLAGS <= DATA_W < BUS_W");
   end
   if (OFS_STAT == OFS_DATA || OFS_STAT == OFS_MASK || OFS_DATA == OFS_MASK) begin : g_bad_map
      $error("sbuf_ctrl: register offsets must differ");
   end
   if (OFS_STAT >= (1 << ADDR_W) || OFS_DATA >= (1 << ADDR_W) || OFS_MASK >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("sbuf_ctrl: offset outside window");
   end

   logic   stat_wr, data_wr, data_rd, mask_wr;
   assign stat_wr = reg_wr && (reg_addr == A_STAT);
   assign data_wr = reg_wr && (reg_addr == A_DATA);
   assign mask_wr = reg_wr && (reg_addr == A_MASK);
   assign data_rd = reg_rd && (reg_addr == A_DATA);

   logic              rx_full, rx_ovf, tx_coll;
   logic [DATA_W-1:0] rx_hold;

   sbuf_tx_slot #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_byte(reg_wdata[DATA_W-1:0]),
      .take(tx_take), .hold_byte(tx_byte), .full(tx_full), .coll(tx_coll));

   sbuf_rx_slot #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .strobe(rx_strobe), .byte_in(rx_byte),
      .rd_en(data_rd), .hold_byte(rx_hold), .full(rx_full), .ovf(rx_ovf));

   flags_t set_v, stat_w, mask_q;
   always_comb begin
      set_v           = '0;
      set_v[FLG_SYNC] = ev_sync;
      set_v[FLG_CONF] = ev_conflict;
      set_v[FLG_OVF]  = rx_ovf;
      set_v[FLG_COLL] = tx_coll;
      set_v[FLG_TOFF] = ev_txoff;
      set_v[FLG_IDLE] = ev_inactive;
   end

   for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_flag
      if (b == FLG_RXF) begin : g_rxf
         assign stat_w[b] = rx_full;
      end else if (b == FLG_TXE) begin : g_txe
         assign stat_w[b] = ~tx_full;
      end else begin : g_evt
         logic q;
         // a new event wins over a clear in the same cycle
         always_ff @(posedge clk) begin
            if (!rst_n)                         q <= 1'b0;
            else if (set_v[b])                  q <= 1'b1;
            else if (stat_wr && reg_wdata[b])   q <= 1'b0;
         end
         assign stat_w[b] = q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= reg_wdata[NUM_FLAGS-1:0];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         unique case (reg_addr)
            A_STAT:  reg_rdata = BUS_W'(stat_w);
            A_DATA:  reg_rdata = BUS_W'(rx_hold);
            A_MASK:  reg_rdata = BUS_W'(mask_q);
            default: reg_rdata = '0;
         endcase
      end
   end

   sbuf_irq_gen #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .flags(stat_w), .mask(mask_q), .irq(irq));

   logic unused_sink;
   assign unused_sink = ^{reg_wdata[BUS_W-1:DATA_W], set_v[FLG_RXF], set_v[FLG_TXE]};

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[BUS_W-1:DATA_W] == '0); // R9
   AST_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && rx_full && !data_rd) |=> stat_w[FLG_OVF]); // R6
   AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_w[FLG_SYNC] && !(stat_wr && reg_wdata[FLG_SYNC])) |=> stat_w[FLG_SYNC]); // R7
   if (IRQ_REG) begin : g_irq_chk
      AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
         (|(stat_w & mask_q)) |=> irq); // R10
      AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(stat_w & mask_q)) |=> !irq); // R10
   end
endmodule

// File: tb/sbuf_ctrl_tb.sv
module sbuf_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic [7:0]  tx_byte;
   logic        tx_full;
   logic        tx_take = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_strobe = 1'b0;
   logic        ev_sync = 1'b0, ev_conflict = 1'b0, ev_txoff = 1'b0, ev_inactive = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sbuf_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .tx_byte(tx_byte), .tx_full(tx_full), .tx_take(tx_take),
      .rx_byte(rx_byte), .rx_strobe(rx_strobe), .ev_sync(ev_sync),
      .ev_conflict(ev_conflict), .ev_txoff(ev_txoff), .ev_inactive(ev_inactive),
      .irq(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse_take();
      @(negedge clk); tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
   endtask

   task automatic pulse_rx(input logic [7:0] b);
      @(negedge clk); rx_byte = b; rx_strobe = 1'b1;
      @(negedge clk); rx_strobe = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 tx_full", {31'b0, tx_full}, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      bus_read(8'h04, v); check("R1 status", v, 32'h04);
      bus_read(8'h0C, v); check("R1 mask", v, 32'h00);
   endtask

   task automatic t_tx_and_collision();
      logic [31:0] v;
      bus_write(8'h08, 32'hFFFF_FFA5);
      check("R2 tx_byte", {24'b0, tx_byte}, 32'hA5);
      check("R2 tx_full", {31'b0, tx_full}, 32'h1);
      bus_read(8'h04, v); check("R2 status", v, 32'h00);
      bus_write(8'h08, 32'h3C);
      check("R3 byte kept", {24'b0, tx_byte}, 32'hA5);
      bus_read(8'h04, v); check("R3 collision flag", v, 32'h20);
      pulse_take();
      check("R4 tx_full", {31'b0, tx_full}, 32'h0);
      bus_read(8'h04, v); check("R4 status", v, 32'h24);
      bus_write(8'h04, 32'h20);
      bus_read(8'h04, v); check("R8 clear collision", v, 32'h04);
      bus_write(8'h08, 32'h3C);
      check("R2 refill", {24'b0, tx_byte}, 32'h3C);
      pulse_take();
   endtask

   task automatic t_rx();
      logic [31:0] v;
      pulse_rx(8'h5A);
      bus_read(8'h04, v); check("R5 rx full", v, 32'h06);
      bus_read(8'h08, v); check("R5 rx data", v, 32'h5A);
      bus_read(8'h04, v); check("R5 rx cleared", v, 32'h04);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      pulse_rx(8'h11);
      pulse_rx(8'h22);
      bus_read(8'h04, v); check("R6 overflow", v, 32'h16);
      bus_write(8'h04, 32'hFF);
      bus_read(8'h04, v); check("R8 bits1-2 kept", v, 32'h06);
      bus_read(8'h08, v); check("R6 overwrite", v, 32'h22);
      bus_read(8'h04, v); check("R5 drained", v, 32'h04);
   endtask

   task automatic t_events();
      logic [31:0] v;
      @(negedge clk); ev_sync = 1'b1; ev_conflict = 1'b1;
      @(negedge clk); ev_sync = 1'b0; ev_conflict = 1'b0; ev_txoff = 1'b1;
      @(negedge clk); ev_txoff = 1'b0; ev_inactive = 1'b1;
      @(negedge clk); ev_inactive = 1'b0;
      repeat (4) @(negedge clk);
      bus_read(8'h04, v); check("R7 sticky events", v, 32'hCD);
      bus_write(8'h04, 32'h09);
      bus_read(8'h04, v); check("R8 partial clear", v, 32'hC4);
      bus_write(8'h04, 32'hC0);
      bus_read(8'h04, v); check("R8 full clear", v, 32'h04);
   endtask

   task automatic t_mask_irq();
      logic [31:0] v;
      bus_write(8'h0C, 32'hFFFF_FFFF);
      bus_read(8'h0C, v); check("R9 mask readback", v, 32'hFF);
      bus_write(8'h0C, 32'h01);
      @(negedge clk); check("R10 masked off", {31'b0, irq}, 32'h0);
      @(negedge clk); ev_sync = 1'b1;
      @(negedge clk); ev_sync = 1'b0;
      check("R10 lag before", {31'b0, irq}, 32'h0);
      @(negedge clk); check("R10 raised", {31'b0, irq}, 32'h1);
      bus_write(8'h04, 32'h01);
      check("R10 still high one cycle", {31'b0, irq}, 32'h1);
      @(negedge clk); check("R10 dropped", {31'b0, irq}, 32'h0);
      bus_write(8'h0C, 32'h04);
      check("R10 mask lag", {31'b0, irq}, 32'h0);
      @(negedge clk); check("R10 txe enabled", {31'b0, irq}, 32'h1);
      bus_write(8'h0C, 32'h00);
      @(negedge clk); check("R10 disabled", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      bus_write(8'h0C, 32'h5A);
      bus_write(8'h10, 32'hFF);
      bus_write(8'h00, 32'hFF);
      bus_read(8'h10, v); check("R11 unmapped read", v, 32'h0);
      bus_read(8'h00, v); check("R11 offset zero read", v, 32'h0);
      bus_read(8'h0C, v); check("R11 mask untouched", v, 32'h5A);
      bus_read(8'h04, v); check("R11 status untouched", v, 32'h04);
      check("R11 tx untouched", {31'b0, tx_full}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx_and_collision();
      t_rx();
      t_overflow();
      t_events();
      t_mask_irq();
      t_unmapped();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule